// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block sits beside a DDR SDRAM command bus on the controller side and follows what each command does to the four internal banks. Every clock it decodes the select, row strobe, column strobe and write-enable lines together with the bank select and address bits. For each bank it keeps an open or closed state and the row most recently opened in it. It enforces the minimum spacing between commands, counted in clock cycles and set by parameters. Any command that breaks a rule is flagged with a one-cycle pulse and a code naming the rule.

The tracker models the two ways a precharge can start. It can come from an explicit command, which address bit 10 widens from the addressed bank to every bank. It can also come from the auto-precharge request carried on a read or write. For an auto-precharge the close is scheduled from the end of the burst and from the bank's minimum open time. A rejected command leaves all bank state untouched, so the tracker keeps describing the device as it really is after a controller error.

Top module: `ddr_bank_tracker`

## Requirements
- R1: Commands are sampled on the rising clock edge. {sel_n, row_strobe_n, col_strobe_n, wr_en_n} = 0011 is activate, 0101 is read, 0100 is write, 0010 is precharge and 0110 is burst stop. With sel_n high, or with any other code, nothing changes and nothing is flagged.
- R2: A legal activate opens the bank chosen by bank_sel_i and stores addr_i[ROW_W-1:0] as its row. Both are visible in the cycle after the command.
- R3: A read or write to a closed bank is flagged with code 4.
- R4: A read or write issued fewer than T_RCD cycles after the activate of its bank is flagged with code 5.
- R5: An activate to a bank that is already open is flagged with code 1.
- R6: An activate fewer than T_RRD cycles after the previous legal activate to any bank is flagged with code 3.
- R7: A precharge with address bit 10 low closes only the addressed bank. It is flagged with code 7 if that bank is open and was activated fewer than T_RAS cycles before.
- R8: A precharge with address bit 10 high closes every bank whatever bank_sel_i holds. It is flagged with code 7 if any open bank was activated fewer than T_RAS cycles before.
- R9: An activate fewer than T_RP cycles after the bank was closed, by command or by auto-precharge, is flagged with code 2.
- R10: A legal read with address bit 10 high closes its bank at cycle t + max(BURST_LEN/2, T_RAS - a). Here t is the read cycle and a is the number of cycles since the bank's activate. This is a CAS latency ahead of the last data on the pins.
- R11: A legal write with address bit 10 high closes its bank at cycle t + max(1 + BURST_LEN/2 + T_WR, T_RAS - a). While an auto-precharge is pending, any read or write to that bank is flagged with code 6.
- R12: A burst stop, including one issued during a write burst, causes no flag and does not move a pending auto-precharge.
- R13: viol_o is registered and goes high only in the cycle after an illegal command, with viol_code_o holding the code. With no violation the code is 0. An illegal command changes no bank state. After reset all banks are closed and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Chip select, active low |
| row_strobe_ni | input | 1 | Row strobe, active low |
| col_strobe_ni | input | 1 | Column strobe, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| bank_sel_i | input | 2 | Bank select |
| addr_i | input | 12 | Row or column address; bit 10 is the precharge-all and auto-precharge flag |
| bank_active_o | output | 4 | One bit per bank, high when open |
| bank_row_o | output | 48 | Open row of each bank, bank b at bits [12b+11:12b] |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 4 | Rule broken (0 none, 1..7 per requirements) |

## Verification
The assertions check some properties on every cycle. A bank only opens after a legal activate to it, and that activate records its row. Open events are never closer than T_RRD. A read or write to a closed bank is always flagged. A precharge-all that is accepted leaves every bank closed. The pulse and its code always agree. The exact cycle at which an auto-precharge closes a bank, under either the burst bound or the T_RAS bound, is shown only by the directed scenarios. The same holds for the T_RP window after that close, the pending-auto-precharge rejection, and a burst stop leaving a write's schedule in place.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_ACT_OPEN  = 4'd1,
    V_ACT_TRP   = 4'd2,
    V_ACT_TRRD  = 4'd3,
    V_RW_IDLE   = 4'd4,
    V_RW_TRCD   = 4'd5,
    V_RW_APPEND = 4'd6,
    V_PRE_TRAS  = 4'd7
  } viol_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic sel_ni,
  input  logic row_strobe_ni,
  input  logic col_strobe_ni,
  input  logic wr_en_ni,
  output cmd_e cmd_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (!sel_ni) begin
      unique case ({row_strobe_ni, col_strobe_ni, wr_en_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP; // refresh, mode set, nop
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state
  import ddr_trk_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int CNT_W     = 3,
  parameter int T_RAS     = 6,
  parameter int RD_AP_DLY = 2,
  parameter int WR_AP_DLY = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             rw_ap_i,
  input  logic             rw_wr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ap_pend_o,
  output logic [CNT_W-1:0] act_age_o,
  output logic [CNT_W-1:0] pre_age_o
);

  localparam logic [CNT_W-1:0] AGE_MAX = '1;
  localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

  logic             active_q, ap_pend_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] ap_cnt_q, act_age_q, pre_age_q, ap_load;
  logic             ap_fire, shut;

  assign ap_fire = ap_pend_q && (ap_cnt_q == '0);
  assign shut    = close_i || ap_fire;

  // close lands at the later of burst end and the T_RAS point
  always_comb begin
    int burst_d, ras_d;
    burst_d = rw_wr_i ? WR_AP_DLY : RD_AP_DLY;
    ras_d   = T_RAS - int'(act_age_q);
    ap_load = CNT_W'(max2(burst_d, ras_d) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      row_q     <= '0;
      ap_pend_q <= 1'b0;
      ap_cnt_q  <= '0;
      act_age_q <= AGE_MAX;
      pre_age_q <= AGE_MAX;
    end else begin
      if (act_i) begin
        active_q  <= 1'b1;
        row_q     <= row_i;
        act_age_q <= AGE_ONE;
      end else if (act_age_q != AGE_MAX) begin
        act_age_q <= act_age_q + 1'b1;
      end

      if (shut) begin
        active_q  <= 1'b0;
        ap_pend_q <= 1'b0;
        pre_age_q <= AGE_ONE;
      end else if (pre_age_q != AGE_MAX) begin
        pre_age_q <= pre_age_q + 1'b1;
      end

      if (rw_ap_i) begin
        ap_pend_q <= 1'b1;
        ap_cnt_q  <= ap_load;
      end else if (ap_pend_q && ap_cnt_q != '0) begin
        ap_cnt_q  <= ap_cnt_q - 1'b1;
      end
    end
  end

  assign active_o  = active_q;
  assign row_o     = row_q;
  assign ap_pend_o = ap_pend_q;
  assign act_age_o = act_age_q;
  assign pre_age_o = pre_age_q;

endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int CNT_W     = 3,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3
) (
  input  cmd_e                            cmd_i,
  input  logic [BA_W-1:0]                 ba_i,
  input  logic                            all_i,
  input  logic [NUM_BANKS-1:0]            active_i,
  input  logic [NUM_BANKS-1:0]            ap_pend_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] act_age_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] pre_age_i,
  input  logic [CNT_W-1:0]                rrd_age_i,
  output viol_e                           code_o
);

  localparam logic [CNT_W-1:0] RCD_C = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] RRD_C = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] RAS_C = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] RP_C  = CNT_W'(T_RP);

  logic [NUM_BANKS-1:0] young;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_young
    assign young[b] = active_i[b] && (act_age_i[b] < RAS_C);
  end

  always_comb begin
    code_o = V_NONE;
    unique case (cmd_i)
      CMD_ACT: begin
        if (active_i[ba_i])                 code_o = V_ACT_OPEN;
        else if (pre_age_i[ba_i] < RP_C)    code_o = V_ACT_TRP;
        else if (rrd_age_i < RRD_C)         code_o = V_ACT_TRRD;
      end
      CMD_RD, CMD_WR: begin
        if (!active_i[ba_i])                code_o = V_RW_IDLE;
        else if (ap_pend_i[ba_i])           code_o = V_RW_APPEND;
        else if (act_age_i[ba_i] < RCD_C)   code_o = V_RW_TRCD;
      end
      CMD_PRE: begin
        if (all_i ? (|young) : young[ba_i]) code_o = V_PRE_TRAS;
      end
      default: code_o = V_NONE;
    endcase
  end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_ni,
  input  logic                       row_strobe_ni,
  input  logic                       col_strobe_ni,
  input  logic                       wr_en_ni,
  input  logic [BA_W-1:0]            bank_sel_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [NUM_BANKS-1:0]       bank_active_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  output logic                       viol_o,
  output logic [3:0]                 viol_code_o
);

  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int RD_AP_DLY = BURST_CYC;
  localparam int WR_AP_DLY = 1 + BURST_CYC + T_WR;
  localparam int MAX_T     = max2(max2(max2(T_RCD, T_RRD), max2(T_RAS, T_RP)), WR_AP_DLY);
  localparam int CNT_W     = $clog2(MAX_T + 2);
  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  cmd_e  cmd;
  viol_e code;
  logic  legal, ap_flag;

  logic [NUM_BANKS-1:0]            active, ap_pend;
  logic [NUM_BANKS-1:0][CNT_W-1:0] act_age, pre_age;
  logic [CNT_W-1:0]                rrd_age_q;
  logic                            viol_q;
  logic [3:0]                      code_q;

  assign ap_flag = addr_i[AP_BIT];

  ddr_cmd_decode u_dec (
    .sel_ni        (sel_ni),
    .row_strobe_ni (row_strobe_ni),
    .col_strobe_ni (col_strobe_ni),
    .wr_en_ni      (wr_en_ni),
    .cmd_o         (cmd)
  );

  ddr_rule_check #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W),
    .CNT_W     (CNT_W),
    .T_RCD     (T_RCD),
    .T_RRD     (T_RRD),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP)
  ) u_rules (
    .cmd_i     (cmd),
    .ba_i      (bank_sel_i),
    .all_i     (ap_flag),
    .active_i  (active),
    .ap_pend_i (ap_pend),
    .act_age_i (act_age),
    .pre_age_i (pre_age),
    .rrd_age_i (rrd_age_q),
    .code_o    (code)
  );

  assign legal = (code == V_NONE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel, act_go, close_go, rw_ap_go;

    assign sel      = (bank_sel_i == BA_W'(b));
    assign act_go   = legal && (cmd == CMD_ACT) && sel;
    assign close_go = legal && (cmd == CMD_PRE) && (ap_flag || sel);
    assign rw_ap_go = legal && ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel && ap_flag;

    ddr_bank_state #(
      .ROW_W     (ROW_W),
      .CNT_W     (CNT_W),
      .T_RAS     (T_RAS),
      .RD_AP_DLY (RD_AP_DLY),
      .WR_AP_DLY (WR_AP_DLY)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act_go),
      .close_i   (close_go),
      .rw_ap_i   (rw_ap_go),
      .rw_wr_i   (cmd == CMD_WR),
      .row_i     (addr_i[ROW_W-1:0]),
      .active_o  (active[b]),
      .row_o     (bank_row_o[b*ROW_W +: ROW_W]),
      .ap_pend_o (ap_pend[b]),
      .act_age_o (act_age[b]),
      .pre_age_o (pre_age[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_age_q <= AGE_MAX;
      viol_q    <= 1'b0;
      code_q    <= '0;
    end else begin
      if (legal && cmd == CMD_ACT)  rrd_age_q <= CNT_W'(1);
      else if (rrd_age_q != AGE_MAX) rrd_age_q <= rrd_age_q + 1'b1;
      viol_q <= !legal;
      code_q <= code;
    end
  end

  assign bank_active_o = active;
  assign viol_o        = viol_q;
  assign viol_code_o   = code_q;

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RRD     = 2,
  parameter int BA_W      = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sel_ni,
  input logic                       row_strobe_ni,
  input logic                       col_strobe_ni,
  input logic                       wr_en_ni,
  input logic [BA_W-1:0]            bank_sel_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [NUM_BANKS-1:0]       bank_active_o,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  input logic                       viol_o,
  input logic [3:0]                 viol_code_o
);

  logic act_c, rw_c, pre_c;
  assign act_c = !sel_ni && !row_strobe_ni &&  col_strobe_ni &&  wr_en_ni;
  assign rw_c  = !sel_ni &&  row_strobe_ni && !col_strobe_ni;
  assign pre_c = !sel_ni && !row_strobe_ni &&  col_strobe_ni && !wr_en_ni;

  logic [NUM_BANKS-1:0] prev_q;
  logic [7:0]           gap_q;
  logic                 rise_any;

  assign rise_any = |(bank_active_o & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      gap_q  <= 8'hff;
    end else begin
      prev_q <= bank_active_o;
      if (rise_any)           gap_q <= 8'd1;
      else if (gap_q != 8'hff) gap_q <= gap_q + 8'd1;
    end
  end

  // R13
  viol_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o == (viol_code_o != 4'd0));

  // R3
  rw_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_c && !bank_active_o[bank_sel_i]) |=> (viol_o && viol_code_o == 4'd4));

  // R8
  pre_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_c && addr_i[AP_BIT]) |=> (viol_o || bank_active_o == '0));

  // R6
  rrd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_any |-> (gap_q >= 8'(T_RRD)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R2
    act_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bank_active_o[b]) |-> ($past(act_c && bank_sel_i == BA_W'(b)) && !viol_o));

    // R2
    act_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_c && bank_sel_i == BA_W'(b)) |=>
        (viol_o || bank_row_o[b*ROW_W +: ROW_W] == $past(addr_i[ROW_W-1:0])));
  end

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .ADDR_W    (ADDR_W),
  .AP_BIT    (AP_BIT),
  .T_RRD     (T_RRD),
  .BA_W      (BA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_ni        (sel_ni),
  .row_strobe_ni (row_strobe_ni),
  .col_strobe_ni (col_strobe_ni),
  .wr_en_ni      (wr_en_ni),
  .bank_sel_i    (bank_sel_i),
  .addr_i        (addr_i),
  .bank_active_o (bank_active_o),
  .bank_row_o    (bank_row_o),
  .viol_o        (viol_o),
  .viol_code_o   (viol_code_o)
);

// File: tb/ddr_bank_tracker_tb.sv
module ddr_bank_tracker_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_DES = 4'b1011;

  localparam logic [11:0] AP = 12'h400;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  active;
  logic [47:0] rows;
  logic        viol;
  logic [3:0]  code;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_bank_tracker u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sel_ni        (sel_n),
    .row_strobe_ni (ras_n),
    .col_strobe_ni (cas_n),
    .wr_en_ni      (we_n),
    .bank_sel_i    (ba),
    .addr_i        (addr),
    .bank_active_o (active),
    .bank_row_o    (rows),
    .viol_o        (viol),
    .viol_code_o   (code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic vchk(input string tag, input int exp_code);
    chk({tag, " viol"}, int'(viol), int'(exp_code != 0));
    chk({tag, " code"}, int'(code), exp_code);
  endtask

  // one command cycle; returns at the next falling edge
  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    {sel_n, ras_n, cas_n, we_n} = c;
    ba   = b;
    addr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(C_NOP, 2'd0, 12'h0);
  endtask

  function automatic int row_of(input int b);
    return int'(rows[b*12 +: 12]);
  endfunction

  task automatic t_reset();
    chk("R13 reset active", int'(active), 0);
    vchk("R13 reset", 0);
  endtask

  task automatic t_trcd();
    step(C_ACT, 2'd0, 12'h123);
    vchk("R2 act", 0);
    chk("R2 active", int'(active[0]), 1);
    chk("R2 row", row_of(0), 12'h123);
    idle(1);
    step(C_RD, 2'd0, 12'h000);
    vchk("R4 early read", 5);
    step(C_RD, 2'd0, 12'h000);
    vchk("R4 read at T_RCD", 0);
    idle(2);
    step(C_PRE, 2'd0, 12'h000);
    vchk("R7 pre legal", 0);
    chk("R7 closed", int'(active[0]), 0);
    idle(6);
  endtask

  task automatic t_idle_rw();
    step(C_RD, 2'd1, 12'h010);
    vchk("R3 read idle", 4);
    step(C_WR, 2'd2, 12'h020);
    vchk("R3 write idle", 4);
    chk("R13 no state change", int'(active), 0);
    idle(1);
    vchk("R13 pulse ends", 0);
  endtask

  task automatic t_open();
    step(C_ACT, 2'd3, 12'h0AA);
    idle(2);
    step(C_ACT, 2'd3, 12'h055);
    vchk("R5 act open bank", 1);
    chk("R13 row kept", row_of(3), 12'h0AA);
    idle(2);
    step(C_PRE, 2'd3, 12'h000);
    vchk("R7 pre b3", 0);
    idle(6);
  endtask

  task automatic t_rrd();
    step(C_ACT, 2'd0, 12'h001);
    step(C_ACT, 2'd1, 12'h002);
    vchk("R6 act too soon", 3);
    chk("R6 b1 closed", int'(active[1]), 0);
    step(C_ACT, 2'd1, 12'h002);
    vchk("R6 act at T_RRD", 0);
    chk("R6 both open", int'(active), 4'b0011);
    idle(5);
    step(C_PRE, 2'd0, AP);
    vchk("R8 pre all", 0);
    chk("R8 all closed", int'(active), 0);
    idle(6);
  endtask

  task automatic t_tras_trp();
    step(C_ACT, 2'd2, 12'h111);
    idle(4);
    step(C_PRE, 2'd2, 12'h000);
    vchk("R7 pre before T_RAS", 7);
    chk("R7 still open", int'(active[2]), 1);
    step(C_PRE, 2'd2, 12'h000);
    vchk("R7 pre at T_RAS", 0);
    chk("R7 closed", int'(active[2]), 0);
    step(C_ACT, 2'd2, 12'h222);
    vchk("R9 act in T_RP", 2);
    chk("R9 row kept", row_of(2), 12'h111);
    idle(1);
    step(C_ACT, 2'd2, 12'h222);
    vchk("R9 act at T_RP", 0);
    chk("R9 new row", row_of(2), 12'h222);
    idle(5);
    step(C_PRE, 2'd2, 12'h000);
    idle(6);
  endtask

  task automatic t_pre_sel_all();
    step(C_ACT, 2'd0, 12'h001);
    idle(1);
    step(C_ACT, 2'd1, 12'h002);
    idle(1);
    step(C_ACT, 2'd3, 12'h003);
    idle(6);
    step(C_PRE, 2'd1, 12'h000);
    chk("R7 only addressed closes", int'(active), 4'b1001);
    step(C_PRE, 2'd1, AP);
    vchk("R8 pre all any ba", 0);
    chk("R8 all closed", int'(active), 0);
    idle(6);
    step(C_ACT, 2'd0, 12'h004);
    idle(5);
    step(C_ACT, 2'd1, 12'h005);
    step(C_PRE, 2'd0, AP);
    vchk("R8 pre all young bank", 7);
    chk("R8 none closed", int'(active), 4'b0011);
    idle(4);
    step(C_PRE, 2'd0, AP);
    vchk("R8 pre all later", 0);
    chk("R8 closed later", int'(active), 0);
    idle(6);
  endtask

  task automatic t_rd_ap();
    step(C_ACT, 2'd2, 12'h333);
    idle(5);
    step(C_RD, 2'd2, AP);
    vchk("R10 read ap", 0);
    chk("R10 open after cmd", int'(active[2]), 1);
    idle(1);
    chk("R10 open t+1", int'(active[2]), 1);
    idle(1);
    chk("R10 closed t+2", int'(active[2]), 0);
    idle(1);
    step(C_ACT, 2'd2, 12'h334);
    vchk("R9 act after ap in T_RP", 2);
    step(C_ACT, 2'd2, 12'h334);
    vchk("R9 act after ap at T_RP", 0);
    idle(5);
    step(C_PRE, 2'd2, 12'h000);
    idle(6);
  endtask

  task automatic t_rd_ap_ras();
    step(C_ACT, 2'd1, 12'h444);
    idle(2);
    step(C_RD, 2'd1, AP);
    vchk("R10 early read ap", 0);
    step(C_RD, 2'd1, 12'h000);
    vchk("R11 read while ap pending", 6);
    idle(1);
    chk("R10 open before T_RAS", int'(active[1]), 1);
    idle(1);
    chk("R10 closed at T_RAS", int'(active[1]), 0);
    idle(6);
  endtask

  task automatic t_wr_ap_bst();
    step(C_ACT, 2'd0, 12'h555);
    idle(5);
    step(C_WR, 2'd0, AP);
    vchk("R11 write ap", 0);
    step(C_BST, 2'd0, 12'h000);
    vchk("R12 bst in write", 0);
    idle(3);
    chk("R12 open t+4", int'(active[0]), 1);
    idle(1);
    chk("R11 closed t+5", int'(active[0]), 0);
    idle(6);
  endtask

  task automatic t_deselect();
    step(C_DES, 2'd0, 12'h321);
    vchk("R1 deselect", 0);
    chk("R1 deselect no open", int'(active), 0);
    step(C_REF, 2'd1, 12'h321);
    vchk("R1 other code", 0);
    chk("R1 other code no open", int'(active), 0);
    step(C_ACT, 2'd1, 12'h0F0);
    chk("R1 act decode", int'(active), 4'b0010);
    idle(5);
    step(C_PRE, 2'd1, 12'h000);
    chk("R1 pre decode", int'(active), 0);
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trcd();
    t_idle_rw();
    t_open();
    t_rrd();
    t_tras_trp();
    t_pre_sel_all();
    t_rd_ap();
    t_rd_ap_ras();
    t_wr_ap_bst();
    t_deselect();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule